// File: doc/BRIEF.md
# Pulse Period and High-Time Meter

The block measures one complete cycle of a single digital input against a free-running tick counter supplied from outside. A one-cycle start pulse arms it; it then waits for the input to rise, notes the tick count, waits for the input to fall, notes the count again, and waits for the next rise. At that third edge it reports the high time (fall minus first rise) and the full period (second rise minus first rise), both in ticks, together with a one-cycle completion pulse and a valid flag.

A timeout guards the measurement. The limit is sampled with the start pulse and counts clock cycles spent measuring. If the three edges have not all been seen by then, the block still pulses completion but clears the valid flag and reports zero for both results. Either way, edge detection is switched off on exit and the block returns to idle until the next start. Conversion of ticks into time units is left to the consumer.

Top module: `cycle_meter`

## Requirements
- R1: While reset is high and in the first cycle after it, done_o and valid_o are 0 and high_o and period_o are 0.
- R2: Measurement starts at the first rising edge of sig_i sampled after the clock edge that accepts start_i; an input already high at start is not a rising edge, and edges seen while idle have no effect.
- R3: The edge being looked for alternates: rising for the first timestamp, falling for the second, rising for the third.
- R4: At completion high_o equals tick at the fall minus tick at the first rise, and period_o equals tick at the second rise minus tick at the first rise, and done_o and valid_o are 1 after the clock edge that samples the second rise.
- R5: After the third timestamp edge detection stops: further input edges raise no done_o and leave valid_o, high_o and period_o unchanged.
- R6: With timeout_len_i = T sampled at start (T = 0 acts as 1), if the measurement is not finished by the T-th clock edge after the start edge, done_o pulses at that edge with valid_o = 0, high_o = 0 and period_o = 0.
- R7: A start pulse while a measurement is running is ignored; the timeout keeps counting from the first start.
- R8: Differences are taken modulo 2^TICK_W, so a single wrap of tick_i during a measurement gives correct results.
- R9: If the completing rising edge falls on the same clock edge as the timeout, the measurement completes with valid_o = 1.
- R10: done_o is high for exactly one cycle per measurement; valid_o, high_o and period_o change only together with done_o and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a measurement |
| timeout_len_i | input | TO_W | Measurement limit in clock cycles, sampled with start |
| sig_i | input | 1 | Signal being measured, synchronous to clk |
| tick_i | input | TICK_W | Free-running timestamp counter |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Last measurement collected all three edges |
| high_o | output | TICK_W | High time in ticks |
| period_o | output | TICK_W | Period in ticks |

## Verification
Every result is registered once: the clock edge that samples the completing rise or the expiring timeout is the edge after which done_o, valid_o, high_o and period_o all carry the new values, and no output moves at any other edge. The bench drives inputs and compares outputs on the falling clock edge, and its behavioural model advances on the rising edge with the same inputs, so each compared value is the one due one register after the stimulus. Timeout boundaries are placed so that the completing edge lands exactly on, or one cycle past, the T-th edge after start.

// File: rtl/cycle_meter_pkg.sv
package cycle_meter_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOW  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'd0,
        SEL_RISE = 2'd1,
        SEL_FALL = 2'd2
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    // Which transition each phase is waiting for.
    function automatic edge_sel_e edge_for(input phase_e ph);
        case (ph)
            PH_ARM:  return SEL_RISE;
            PH_HIGH: return SEL_FALL;
            PH_LOW:  return SEL_RISE;
            default: return SEL_OFF;
        endcase
    endfunction

    function automatic logic edge_hit(input edge_sel_e sel, input edge_ev_t ev);
        return ((sel == SEL_RISE) && ev.rise) || ((sel == SEL_FALL) && ev.fall);
    endfunction

endpackage

// File: rtl/cm_edge_det.sv
module cm_edge_det
    import cycle_meter_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sig_i,
    output edge_ev_t ev_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_i;
    end

    always_comb begin
        ev_o.rise = sig_i & ~sig_q;
        ev_o.fall = ~sig_i & sig_q;
    end
endmodule

// File: rtl/cm_timeout.sv
module cm_timeout #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [TO_W-1:0] lim_i,
    input  logic            run_i,
    output logic            expire_o
);
    localparam int EXT_W = TO_W + 1;

    logic [TO_W-1:0] cnt_q;
    logic [TO_W-1:0] lim_q;
    logic [EXT_W-1:0] next_ext;

    assign next_ext = {1'b0, cnt_q} + EXT_W'(1);
    assign expire_o = run_i && (next_ext >= {1'b0, lim_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= lim_i;
        end else if (run_i && !expire_o) begin
            cnt_q <= cnt_q + TO_W'(1);
        end
    end
endmodule

// File: rtl/cm_seq.sv
module cm_seq
    import cycle_meter_pkg::*;
#(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  edge_ev_t          ev_i,
    input  logic [TICK_W-1:0] tick_i,
    input  logic              expire_i,
    output logic              load_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              valid_o,
    output logic [TICK_W-1:0] high_o,
    output logic [TICK_W-1:0] period_o
);
    phase_e            ph_q;
    logic [TICK_W-1:0] snap_rise_q;
    logic [TICK_W-1:0] snap_fall_q;
    edge_sel_e         sel;
    logic              hit;
    logic              last;

    assign sel    = edge_for(ph_q);
    assign hit    = edge_hit(sel, ev_i);
    assign last   = hit && (ph_q == PH_LOW);
    assign busy_o = (ph_q != PH_IDLE);
    assign load_o = start_i && (ph_q == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q        <= PH_IDLE;
            snap_rise_q <= '0;
            snap_fall_q <= '0;
            done_o      <= 1'b0;
            valid_o     <= 1'b0;
            high_o      <= '0;
            period_o    <= '0;
        end else begin
            done_o <= 1'b0;
            if (ph_q == PH_IDLE) begin
                if (start_i) ph_q <= PH_ARM;
            end else if (last) begin
                done_o   <= 1'b1;
                valid_o  <= 1'b1;
                high_o   <= snap_fall_q - snap_rise_q;
                period_o <= tick_i - snap_rise_q;
                ph_q     <= PH_IDLE;
            end else if (expire_i) begin
                done_o   <= 1'b1;
                valid_o  <= 1'b0;
                high_o   <= '0;
                period_o <= '0;
                ph_q     <= PH_IDLE;
            end else if (hit) begin
                if (ph_q == PH_ARM) begin
                    snap_rise_q <= tick_i;
                    ph_q        <= PH_HIGH;
                end else begin
                    snap_fall_q <= tick_i;
                    ph_q        <= PH_LOW;
                end
            end
        end
    end
endmodule

// File: rtl/cycle_meter.sv
module cycle_meter
    import cycle_meter_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int TO_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [TO_W-1:0]   timeout_len_i,
    input  logic              sig_i,
    input  logic [TICK_W-1:0] tick_i,
    output logic              done_o,
    output logic              valid_o,
    output logic [TICK_W-1:0] high_o,
    output logic [TICK_W-1:0] period_o
);
    edge_ev_t ev;
    logic     load;
    logic     busy;
    logic     expire;

    cm_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .sig_i (sig_i),
        .ev_o  (ev)
    );

    cm_timeout #(.TO_W(TO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .lim_i    (timeout_len_i),
        .run_i    (busy),
        .expire_o (expire)
    );

    cm_seq #(.TICK_W(TICK_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .ev_i     (ev),
        .tick_i   (tick_i),
        .expire_i (expire),
        .load_o   (load),
        .busy_o   (busy),
        .done_o   (done_o),
        .valid_o  (valid_o),
        .high_o   (high_o),
        .period_o (period_o)
    );
endmodule

// File: rtl/cycle_meter_chk.sv
module cycle_meter_chk #(
    parameter int TICK_W = 32,
    parameter int TO_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [TO_W-1:0]   timeout_len_i,
    input logic              busy,
    input logic              done_o,
    input logic              valid_o,
    input logic [TICK_W-1:0] high_o,
    input logic [TICK_W-1:0] period_o
);
    logic [TO_W-1:0] c_cnt;
    logic [TO_W-1:0] c_lim;
    logic [TO_W-1:0] c_lim_eff;

    assign c_lim_eff = (c_lim == '0) ? TO_W'(1) : c_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_cnt <= '0;
            c_lim <= '0;
        end else if (start_i && !busy) begin
            c_cnt <= '0;
            c_lim <= timeout_len_i;
        end else if (busy) begin
            c_cnt <= c_cnt + TO_W'(1);
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(valid_o) && $stable(high_o) && $stable(period_o))); // R10
    AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_o && !valid_o) |-> (high_o == '0 && period_o == '0)); // R6
    AST_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        busy |-> (c_cnt < c_lim_eff)); // R6
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_i)); // R2
    AST_EXIT_SIGNALS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_o); // R5
    AST_DONE_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy); // R5
endmodule

bind cycle_meter cycle_meter_chk #(.TICK_W(TICK_W), .TO_W(TO_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .timeout_len_i (timeout_len_i),
    .busy          (busy),
    .done_o        (done_o),
    .valid_o       (valid_o),
    .high_o        (high_o),
    .period_o      (period_o)
);

// File: tb/cycle_meter_tb.sv
module cycle_meter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [15:0] timeout_len_i;
    logic        sig_i;
    logic [31:0] tick_i;
    logic        done_o;
    logic        valid_o;
    logic [31:0] high_o;
    logic [31:0] period_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // behavioural reference
    int          m_phase;
    int          m_cnt;
    int          m_lim;
    logic [31:0] snaps[$];
    bit          m_prev;
    bit          m_done;
    bit          m_valid;
    logic [31:0] m_high;
    logic [31:0] m_period;
    bit          rise;
    bit          fall;
    bit          got;

    always #(CLK_PERIOD/2) clk = ~clk;

    cycle_meter u_dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .timeout_len_i (timeout_len_i),
        .sig_i         (sig_i),
        .tick_i        (tick_i),
        .done_o        (done_o),
        .valid_o       (valid_o),
        .high_o        (high_o),
        .period_o      (period_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_lim = 0; snaps.delete();
            m_prev = 0; m_done = 0; m_valid = 0; m_high = 0; m_period = 0;
        end else begin
            rise = sig_i && !m_prev;
            fall = !sig_i && m_prev;
            m_done = 0;
            if (m_phase == 0) begin
                if (start_i) begin
                    m_phase = 1; m_cnt = 0; m_lim = int'(timeout_len_i); snaps.delete();
                end
            end else begin
                got = (m_phase == 1 && rise) || (m_phase == 2 && fall) || (m_phase == 3 && rise);
                if (got && m_phase == 3) begin
                    snaps.push_back(tick_i);
                    m_done = 1; m_valid = 1;
                    m_high = snaps[1] - snaps[0];
                    m_period = snaps[2] - snaps[0];
                    m_phase = 0;
                end else if (m_cnt + 1 >= m_lim) begin
                    m_done = 1; m_valid = 0; m_high = 0; m_period = 0; m_phase = 0;
                end else begin
                    if (got) begin
                        snaps.push_back(tick_i);
                        m_phase++;
                    end
                    m_cnt++;
                end
            end
            m_prev = sig_i;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(cur_req, "done_o",   {31'b0, done_o},  {31'b0, m_done});
            check(cur_req, "valid_o",  {31'b0, valid_o}, {31'b0, m_valid});
            check(cur_req, "high_o",   high_o,   m_high);
            check(cur_req, "period_o", period_o, m_period);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = tick_i + 32'd1;
        end
    endtask

    task automatic kick(input logic [15:0] lim);
        timeout_len_i = lim;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
    endtask

    // rise now, fall after hi steps, rise again after lo steps
    task automatic wave(input int hi, input int lo);
        sig_i = 1'b1; step(hi);
        sig_i = 1'b0; step(lo);
        sig_i = 1'b1; step();
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; sig_i = 1'b0; tick_i = 32'd100; timeout_len_i = 16'd100;
        step(3);
        check("R1", "done in reset", {31'b0, done_o}, 32'd0);
        check("R1", "valid in reset", {31'b0, valid_o}, 32'd0);
        rst = 1'b0;
        step();
        check("R1", "high after reset", high_o, 32'd0);
        check("R1", "period after reset", period_o, 32'd0);
        cmp_on = 1'b1;

        cur_req = "R2"; sig_i = 1'b1; step(2); sig_i = 1'b0; step(2);  // idle edges
        check("R2", "no done from idle edges", {31'b0, done_o}, 32'd0);

        cur_req = "R4"; kick(16'd100); wave(5, 7); step(3);
        check("R4", "high basic", high_o, 32'd5);
        check("R3", "period basic", period_o, 32'd12);
        check("R4", "valid basic", {31'b0, valid_o}, 32'd1);

        cur_req = "R5"; sig_i = 1'b0; step(2); sig_i = 1'b1; step(2); sig_i = 1'b0; step(3);
        check("R5", "high held", high_o, 32'd5);
        check("R5", "period held", period_o, 32'd12);

        cur_req = "R2"; sig_i = 1'b1; step(2); kick(16'd100); step(3);
        sig_i = 1'b0; step(2); wave(4, 3); step(2);
        check("R2", "high level-at-start", high_o, 32'd4);
        check("R2", "period level-at-start", period_o, 32'd7);
        sig_i = 1'b0; step(2);

        cur_req = "R6"; kick(16'd8); step(12);
        check("R6", "valid after silent timeout", {31'b0, valid_o}, 32'd0);
        check("R6", "high after timeout", high_o, 32'd0);
        kick(16'd10); sig_i = 1'b1; step(2); sig_i = 1'b0; step(15);
        check("R6", "period two edges", period_o, 32'd0);
        kick(16'd0); step(4);
        check("R6", "zero limit valid", {31'b0, valid_o}, 32'd0);

        cur_req = "R7"; kick(16'd10); step(6); kick(16'd10); wave(2, 2); step(12);
        check("R7", "restart ignored", {31'b0, valid_o}, 32'd0);
        sig_i = 1'b0; step(2);

        cur_req = "R8"; tick_i = 32'hFFFF_FFF8; kick(16'd100); wave(6, 4); step(2);
        check("R8", "high across wrap", high_o, 32'd6);
        check("R8", "period across wrap", period_o, 32'd10);
        sig_i = 1'b0; step(2);

        cur_req = "R9"; kick(16'd6); wave(2, 3); step(2);
        check("R9", "completion at limit valid", {31'b0, valid_o}, 32'd1);
        check("R9", "completion at limit period", period_o, 32'd5);
        sig_i = 1'b0; step(2);
        kick(16'd5); wave(2, 3); step(2);
        check("R9", "one past limit", {31'b0, valid_o}, 32'd0);
        sig_i = 1'b0; step(2);

        cur_req = "R10"; kick(16'd50); wave(3, 1); step(4);
        check("R10", "done drops", {31'b0, done_o}, 32'd0);
        check("R10", "high kept", high_o, 32'd3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule